// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master with Region Port-Width Control

This block is the external bus master of a processor. It takes one transfer request at a time from the core and runs it on a shared 32-bit address/data bus. A transfer is a single access of one to four bytes or a burst of four words, in either direction. Each transaction has an address cycle and then one or more data cycles. During the address cycle the upper bus lines carry the address and the lowest four lines carry a size code. During the data cycles the bus carries write data from the master, or read data from the target.

The two top address bits select one of four regions. A parameter table gives each region a port width and an idle gap. The port width is driven on the width pins and also decides how the byte-enable pins are coded. The target ends each data cycle with an acknowledge, a retry request or a bus error. A retry restarts the whole transaction from its address cycle. A read may only be retried before any data has been accepted; a write may be retried in any data cycle. A bus error ends the transaction at once and reports an error to the core. After every transaction the master keeps the bus idle for the region's idle gap before it starts the next one.

Top module: `mux_bus_master`

## Requirements
- R1: The address cycle lasts exactly one clock. In it `ale` is 1 and `ads_n` is 0. `ad_out[31:4]` carries the address. `ad_out[3:0]` carries the size code: 0000 for a four-word burst, and 0001, 0010, 0011 or 0100 for a single access of 1, 2, 3 or 4 bytes. `ad_oe` is 1.
- R2: While a transaction is active, `width` shows the port width of the region chosen by address bits [31:30]: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit. The default table maps regions 0 and 1 to 32-bit, region 2 to 16-bit and region 3 to 8-bit. When the bus is idle, `width` is 00.
- R3: `be_n` is active low and is 1111 when the bus is idle. Covered bytes run from address[1:0] for the requested byte count; a burst covers all four. On a 32-bit port, `be_n[i]` is low when byte i is covered. On a 16-bit port, with h = address bit 1: `be_n[3]` is low when byte 2h+1 is covered, `be_n[2]` is 1, `be_n[1]` equals address bit 1, and `be_n[0]` is low when byte 2h is covered. On an 8-bit port, `be_n` = {1, 1, address bit 1, address bit 0}.
- R4: `cip_n` is low from the address cycle until the acknowledge of the last data cycle is sampled. It is high in the clock after that.
- R5: `den_n` is low only in data cycles. `last_n` is low only in the final data cycle: beat 3 of a burst, or the only beat of a single access.
- R6: `rd_n` is low during an active read and `wr_n` is low during an active write. `dtr` is 1 during an active write and 0 otherwise. `instr` is 1 during an active instruction transfer.
- R7: `addr_word` is the start word (address bits [3:2]) XOR the beat number. In write data cycles `ad_out` drives word w of `req_wdata`, taken from bits [32w+31:32w], and `ad_oe` is 1.
- R8: In the clock after an acknowledged read data cycle, `rsp_valid` is 1, `rsp_rdata` holds the sampled `ad_in`, and `rsp_last` marks the final beat. A write gives one response, with `rsp_last` = 1, after its final acknowledge.
- R9: A read retry seen before the first acknowledge restarts the transaction at its address cycle. Once a read beat has been acknowledged, later retries are ignored. Retry takes priority over an acknowledge in the same cycle.
- R10: A write retry seen in any data cycle restarts the transaction at its address cycle, with beat 0.
- R11: A bus error in a data cycle ends the transaction in the next clock. In that clock `cip_n` is 1 and `rsp_valid`, `rsp_err` and `rsp_last` are 1. A bus error takes priority over retry and acknowledge.
- R12: After a transaction ends, `req_ready` stays 0 for the region's idle-gap count of clocks. The next `ale` therefore follows at least gap+1 idle clocks later. The default gap for region r is r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_nbytes | input | 3 | Byte count 1..4 for a single access |
| req_burst | input | 1 | Four-word burst |
| req_instr | input | 1 | Instruction transfer |
| req_wdata | input | 128 | Write words, word w at bits [32w+31:32w] |
| req_ready | output | 1 | Master idle and gap elapsed |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Response ended by bus error |
| rsp_last | output | 1 | Final response of the transaction |
| rsp_rdata | output | 32 | Read data |
| ad_out | output | 32 | Address/data bus, driven value |
| ad_oe | output | 1 | Bus drive enable |
| ad_in | input | 32 | Address/data bus, received value |
| addr_word | output | 2 | Word within line |
| ale | output | 1 | Address latch enable |
| ads_n | output | 1 | Address strobe, active low |
| width | output | 2 | Port width code |
| be_n | output | 4 | Byte enables, active low |
| cip_n | output | 1 | Cycle in progress, active low |
| instr | output | 1 | Instruction transfer |
| rd_n | output | 1 | Read, active low |
| wr_n | output | 1 | Write, active low |
| den_n | output | 1 | Data cycle, active low |
| dtr | output | 1 | Data direction, 1 = write |
| last_n | output | 1 | Final data cycle, active low |
| ack_n | input | 1 | Acknowledge, active low |
| retry_n | input | 1 | Retry, active low |
| berr_n | input | 1 | Bus error, active low |

## Verification
A wrong beat counter shows up in the next data cycle: `addr_word`, `last_n` or the write word is wrong there, and in a burst the transaction also ends early or late. A sequencer that gets retry or bus error wrong shows in the next clock, as a missing or extra `ale` or a `cip_n` that is still low. A wrong idle-gap counter changes when `req_ready` rises and shifts the next `ale` by the same number of clocks. The cycle model in the bench catches each of these faults in the clock where it first appears.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    localparam int WORD_W      = 32;
    localparam int BURST_BEATS = 4;
    localparam int BEAT_W      = $clog2(BURST_BEATS);
    localparam int LANES       = WORD_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } bus_state_e;

    typedef enum logic [1:0] {
        PW_8   = 2'b00,
        PW_16  = 2'b01,
        PW_32  = 2'b10,
        PW_RSV = 2'b11
    } port_width_e;

    typedef struct packed {
        logic [WORD_W-1:0]             addr;
        logic                          write;
        logic [2:0]                    nbytes;
        logic                          burst;
        logic                          instr;
        logic [BURST_BEATS*WORD_W-1:0] wdata;
    } xfer_req_t;

    // Size code driven on the low bus lines in the address cycle
    function automatic logic [3:0] size_code(input logic burst, input logic [2:0] nbytes);
        return burst ? 4'b0000 : {1'b0, nbytes};
    endfunction

    // Byte lanes covered by an access
    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] a,
                                                   input logic [2:0] nb,
                                                   input logic       burst);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++)
            m[i] = burst || ((i >= int'(a)) && (i < int'(a) + int'(nb)));
        return m;
    endfunction

endpackage

// File: rtl/mbm_region_lut.sv
module mbm_region_lut
    import mbm_pkg::*;
#(
    parameter int REGION_BITS = 2,
    parameter int TA_W        = 3,
    parameter logic [2*(1<<REGION_BITS)-1:0]    WIDTHS = 8'b00_01_10_10,
    parameter logic [TA_W*(1<<REGION_BITS)-1:0] GAPS   = 12'o3210
) (
    input  logic [REGION_BITS-1:0] sel,
    output port_width_e            pw,
    output logic [TA_W-1:0]        gap
);
    localparam int NREG = 1 << REGION_BITS;

    logic [1:0]      w_tab [NREG];
    logic [TA_W-1:0] g_tab [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign w_tab[g] = WIDTHS[2*g +: 2];
        assign g_tab[g] = GAPS[TA_W*g +: TA_W];
    end

    assign pw  = port_width_e'(w_tab[sel]);
    assign gap = g_tab[sel];

endmodule

// File: rtl/mbm_lane_enc.sv
module mbm_lane_enc
    import mbm_pkg::*;
(
    input  port_width_e      pw,
    input  logic [1:0]       a,
    input  logic [2:0]       nb,
    input  logic             burst,
    input  logic             en,
    output logic [LANES-1:0] be_n
);
    logic [LANES-1:0] m;

    always_comb begin
        m    = lane_mask(a, nb, burst);
        be_n = '1;
        if (en) begin
            unique case (pw)
                PW_32:   be_n = ~m;
                PW_16:   be_n = {~m[{a[1], 1'b1}], 1'b1, a[1], ~m[{a[1], 1'b0}]};
                PW_8:    be_n = {1'b1, 1'b1, a[1], a[0]};
                default: be_n = '1;
            endcase
        end
    end

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
    import mbm_pkg::*;
#(
    parameter int REGION_BITS = 2,
    parameter int TA_W        = 3,
    parameter logic [2*(1<<REGION_BITS)-1:0]    REGION_WIDTH = 8'b00_01_10_10,
    parameter logic [TA_W*(1<<REGION_BITS)-1:0] REGION_GAP   = 12'o3210
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic [31:0]  req_addr,
    input  logic         req_write,
    input  logic [2:0]   req_nbytes,
    input  logic         req_burst,
    input  logic         req_instr,
    input  logic [127:0] req_wdata,
    output logic         req_ready,
    output logic         rsp_valid,
    output logic         rsp_err,
    output logic         rsp_last,
    output logic [31:0]  rsp_rdata,
    output logic [31:0]  ad_out,
    output logic         ad_oe,
    input  logic [31:0]  ad_in,
    output logic [1:0]   addr_word,
    output logic         ale,
    output logic         ads_n,
    output logic [1:0]   width,
    output logic [3:0]   be_n,
    output logic         cip_n,
    output logic         instr,
    output logic         rd_n,
    output logic         wr_n,
    output logic         den_n,
    output logic         dtr,
    output logic         last_n,
    input  logic         ack_n,
    input  logic         retry_n,
    input  logic         berr_n
);
    bus_state_e        state;
    xfer_req_t         cur;
    port_width_e       cur_pw;
    logic [TA_W-1:0]   cur_gap;
    logic [TA_W-1:0]   gap_cnt;
    logic [BEAT_W-1:0] beat;

    port_width_e       lut_pw;
    logic [TA_W-1:0]   lut_gap;
    logic              active, final_beat, retry_ok;
    logic [BEAT_W-1:0] word;

    mbm_region_lut #(
        .REGION_BITS(REGION_BITS), .TA_W(TA_W),
        .WIDTHS(REGION_WIDTH), .GAPS(REGION_GAP)
    ) u_lut (
        .sel (req_addr[31 -: REGION_BITS]),
        .pw  (lut_pw),
        .gap (lut_gap)
    );

    assign active     = (state != ST_IDLE);
    assign final_beat = !cur.burst || (beat == BEAT_W'(BURST_BEATS-1));
    assign word       = cur.addr[3:2] ^ beat;
    assign retry_ok   = cur.write || (beat == '0);

    mbm_lane_enc u_lanes (
        .pw    (cur_pw),
        .a     (cur.addr[1:0]),
        .nb    (cur.nbytes),
        .burst (cur.burst),
        .en    (active),
        .be_n  (be_n)
    );

    // Transaction sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur       <= '0;
            cur_pw    <= PW_8;
            cur_gap   <= '0;
            gap_cnt   <= '0;
            beat      <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_last  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_last  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (gap_cnt != '0) begin
                        gap_cnt <= gap_cnt - 1'b1;
                    end else if (req_valid) begin
                        cur     <= '{addr: req_addr, write: req_write, nbytes: req_nbytes,
                                     burst: req_burst, instr: req_instr, wdata: req_wdata};
                        cur_pw  <= lut_pw;
                        cur_gap <= lut_gap;
                        beat    <= '0;
                        state   <= ST_ADDR;
                    end
                end
                ST_ADDR: state <= ST_DATA;
                ST_DATA: begin
                    if (!berr_n) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b1;
                        rsp_last  <= 1'b1;
                        gap_cnt   <= cur_gap;
                        beat      <= '0;
                        state     <= ST_IDLE;
                    end else if (!retry_n && retry_ok) begin
                        beat  <= '0;
                        state <= ST_ADDR;
                    end else if (!ack_n) begin
                        if (!cur.write) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= ad_in;
                            rsp_last  <= final_beat;
                        end
                        if (final_beat) begin
                            if (cur.write) begin
                                rsp_valid <= 1'b1;
                                rsp_last  <= 1'b1;
                            end
                            gap_cnt <= cur_gap;
                            beat    <= '0;
                            state   <= ST_IDLE;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus pins decoded from the sequencer state
    always_comb begin
        ale       = (state == ST_ADDR);
        ads_n     = !ale;
        cip_n     = !active;
        rd_n      = !(active && !cur.write);
        wr_n      = !(active && cur.write);
        dtr       = active && cur.write;
        instr     = active && cur.instr;
        den_n     = !(state == ST_DATA);
        last_n    = !((state == ST_DATA) && final_beat);
        width     = active ? cur_pw : 2'b00;
        addr_word = active ? word : '0;
        req_ready = (state == ST_IDLE) && (gap_cnt == '0);
        ad_oe     = ale || ((state == ST_DATA) && cur.write);
        if (ale)
            ad_out = {cur.addr[31:4], size_code(cur.burst, cur.nbytes)};
        else if ((state == ST_DATA) && cur.write)
            ad_out = cur.wdata[{word, 5'b0} +: WORD_W];
        else
            ad_out = '0;
    end

    a_r1_addr_one_clock: assert property (@(posedge clk) disable iff (rst)
        ale |=> (!ale && !den_n));

    a_r4_cip_release: assert property (@(posedge clk) disable iff (rst)
        (!last_n && !ack_n && retry_n && berr_n) |=> cip_n);

    a_r9_read_retry_late: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && !cur.write && beat != '0) |=> !ale);

    a_r10_write_retry: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && cur.write && !retry_n && berr_n) |=> (ale && addr_word == cur.addr[3:2]));

    a_r11_berr_ends: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && !berr_n) |=> (rsp_valid && rsp_err && cip_n));

    a_r12_gap_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && gap_cnt != '0) |=> !ale);

    a_r6_dir_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!rd_n, !wr_n}));

endmodule

// File: tb/mux_bus_master_tb.sv
`timescale 1ns/1ps
module mux_bus_master_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_write = 1'b0;
    logic [2:0]   req_nbytes = 3'd4;
    logic         req_burst = 1'b0;
    logic         req_instr = 1'b0;
    logic [127:0] req_wdata = '0;
    logic         req_ready, rsp_valid, rsp_err, rsp_last;
    logic [31:0]  rsp_rdata, ad_out;
    logic         ad_oe;
    logic [31:0]  ad_in = '0;
    logic [1:0]   addr_word, width;
    logic         ale, ads_n, cip_n, instr, rd_n, wr_n, den_n, dtr, last_n;
    logic [3:0]   be_n;
    logic         ack_n = 1'b1, retry_n = 1'b1, berr_n = 1'b1;

    always #2.5 clk = ~clk;

    mux_bus_master u_dut (.*);

    int n_checks = 0, n_fails = 0;
    bit cmp_on = 0;
    int rq[$];
    int dctr = 0, ale_cnt = 0, err_cnt = 0, rsp_cnt = 0, idle_run = 0, last_gap = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
        end
    endtask

    // Region table as stated in R2/R12
    function automatic int exp_width(input int r);
        return (r == 3) ? 0 : (r == 2) ? 1 : 2;
    endfunction

    function automatic logic [3:0] exp_be(input int w, input int a, input int nb, input bit burst);
        bit cov[4];
        logic [3:0] b;
        int h;
        for (int i = 0; i < 4; i++) cov[i] = burst || (i >= a && i < a + nb);
        h = (a >> 1) & 1;
        if (w == 2) begin
            for (int i = 0; i < 4; i++) b[i] = !cov[i];
        end else if (w == 1) begin
            b = {!cov[2*h+1], 1'b1, 1'(h), !cov[2*h]};
        end else begin
            b = {2'b11, 1'(h), 1'(a & 1)};
        end
        return b;
    endfunction

    // Behavioural cycle model
    int ms = 0, mbeat = 0, mcnt = 0, mnb = 0, mwid = 0, mta = 0;
    bit mw = 0, mburst = 0, minstr = 0;
    logic [31:0] maddr = '0, mrd = '0;
    logic [127:0] mwd = '0;
    bit mrv = 0, mre = 0, mrl = 0;

    always @(posedge clk) begin
        bit fin;
        fin = !mburst || mbeat == 3;
        mrv = 0; mre = 0; mrl = 0;
        if (rst) begin
            ms = 0; mcnt = 0; mbeat = 0; mrd = '0;
        end else if (ms == 0) begin
            if (mcnt > 0) mcnt--;
            else if (req_valid) begin
                maddr = req_addr; mw = req_write; mnb = int'(req_nbytes);
                mburst = req_burst; minstr = req_instr; mwd = req_wdata;
                mwid = exp_width(int'(req_addr[31:30])); mta = int'(req_addr[31:30]);
                mbeat = 0; ms = 1;
            end
        end else if (ms == 1) begin
            ms = 2;
        end else begin
            if (!berr_n) begin
                mrv = 1; mre = 1; mrl = 1; ms = 0; mcnt = mta; mbeat = 0;
            end else if (!retry_n && (mw || mbeat == 0)) begin
                ms = 1; mbeat = 0;
            end else if (!ack_n) begin
                if (!mw) begin mrv = 1; mrd = ad_in; mrl = fin; end
                if (fin) begin
                    if (mw) begin mrv = 1; mrl = 1; end
                    ms = 0; mcnt = mta; mbeat = 0;
                end else mbeat++;
            end
        end
    end

    // Compare, monitor and target responder, all at the falling edge
    always @(negedge clk) begin
        bit act, fin;
        int wd, code;
        logic [31:0] e_ad;
        if (cmp_on) begin
            act = ms != 0;
            fin = !mburst || mbeat == 3;
            wd  = act ? (int'(maddr[3:2]) ^ mbeat) : 0;
            e_ad = (ms == 1) ? {maddr[31:4], (mburst ? 4'b0000 : 4'(mnb))} :
                   (ms == 2 && mw) ? mwd[wd*32 +: 32] : 32'h0;
            chk(ale == (ms == 1) && ads_n == !(ms == 1), "R1 ale/ads_n", {ale, ads_n}, {ms == 1, ms != 1});
            chk(ad_out == e_ad && ad_oe == (ms == 1 || (ms == 2 && mw)), "R1/R7 ad_out", ad_out, e_ad);
            chk(width == (act ? 2'(mwid) : 2'b00), "R2 width", width, act ? mwid : 0);
            chk(be_n == (act ? exp_be(mwid, int'(maddr[1:0]), mnb, mburst) : 4'hF), "R3 be_n", be_n,
                act ? exp_be(mwid, int'(maddr[1:0]), mnb, mburst) : 4'hF);
            chk(cip_n == !act, "R4 cip_n", cip_n, !act);
            chk(den_n == !(ms == 2) && last_n == !(ms == 2 && fin), "R5 den_n/last_n",
                {den_n, last_n}, {ms != 2, !(ms == 2 && fin)});
            chk(rd_n == !(act && !mw) && wr_n == !(act && mw) && dtr == (act && mw) && instr == (act && minstr),
                "R6 rd/wr/dtr/instr", {rd_n, wr_n, dtr, instr}, {!(act && !mw), !(act && mw), act && mw, act && minstr});
            chk(addr_word == 2'(wd), "R7 addr_word", addr_word, wd);
            chk(rsp_valid == mrv && rsp_err == mre && rsp_last == mrl && (!(mrv && !mre && !mw) || rsp_rdata == mrd),
                "R8 response", {rsp_valid, rsp_err, rsp_last, rsp_rdata}, {mrv, mre, mrl, mrd});
            chk(req_ready == (ms == 0 && mcnt == 0), "R12 req_ready", req_ready, ms == 0 && mcnt == 0);
            if (ale) begin last_gap = idle_run; ale_cnt++; end
            if (cip_n) idle_run++; else idle_run = 0;
            if (rsp_valid && rsp_err) err_cnt++;
            if (rsp_valid) rsp_cnt++;
        end
        ack_n = 1'b1; retry_n = 1'b1; berr_n = 1'b1;
        if (!den_n) begin
            code = (rq.size() > 0) ? rq.pop_front() : 1;
            ack_n   = !(code == 1 || code == 4);
            retry_n = !(code == 2 || code == 4);
            berr_n  = !(code == 3);
            ad_in   = 32'hA500_0000 + 32'(dctr);
            dctr++;
        end
    end

    // Codes in scr: 0 wait, 1 ack, 2 retry, 3 bus error, 4 ack with retry
    task automatic run(input logic [31:0] a, input bit w, input int nb, input bit b, input bit ins,
                       input int scr[$], input int exp_ale, input int exp_err, input string tag);
        int a0, e0;
        while (!req_ready) @(negedge clk);
        rq = scr;
        a0 = ale_cnt; e0 = err_cnt;
        req_addr = a; req_write = w; req_nbytes = 3'(nb); req_burst = b; req_instr = ins;
        req_wdata = {32'h3333_0003, 32'h2222_0002, 32'h1111_0001, 32'h0000_0000} ^ {4{a}};
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!cip_n) @(negedge clk);
        #1;
        chk(ale_cnt - a0 == exp_ale, {tag, " address cycles"}, ale_cnt - a0, exp_ale);
        chk(err_cnt - e0 == exp_err, {tag, " error responses"}, err_cnt - e0, exp_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cip_n == 1 && ale == 0 && be_n == 4'hF && req_ready == 1 && rsp_valid == 0,
            "R4/R12 reset state", {cip_n, ale, be_n, req_ready}, {1'b1, 1'b0, 4'hF, 1'b1});
        rst = 1'b0;
        cmp_on = 1;
        @(negedge clk);
        run(32'h0000_0010, 0, 4, 0, 1, '{0, 1},          1, 0, "R8 single read");
        run(32'h4000_0006, 1, 2, 0, 0, '{1},             1, 0, "R6 single write");
        run(32'h8000_0028, 0, 4, 1, 1, '{1, 0, 1, 1, 1}, 1, 0, "R7 burst read 16-bit");
        run(32'h0000_0034, 1, 4, 1, 0, '{1, 2, 1, 1, 1, 1}, 2, 0, "R10 write retry");
        run(32'hC000_0003, 0, 1, 0, 0, '{2, 1},          2, 0, "R9 read retry early");
        run(32'h0000_0000, 0, 4, 1, 0, '{1, 4, 1, 1},    1, 0, "R9 read retry late");
        run(32'h4000_0001, 0, 3, 0, 0, '{3},             1, 1, "R11 bus error");
        run(32'h8000_0005, 1, 1, 0, 0, '{1},             1, 0, "R3 16-bit byte write");
        run(32'h8000_0006, 0, 2, 1, 0, '{1, 3},          1, 1, "R11 burst error");
        run(32'hC000_0002, 1, 2, 0, 0, '{1},             1, 0, "R3 8-bit write");
        run(32'hC000_0001, 0, 1, 0, 0, '{1},             1, 0, "R12 back to back");
        chk(last_gap == 4, "R12 idle clocks before address cycle", last_gap, 4);
        run(32'h0000_0008, 0, 2, 0, 0, '{1},             1, 0, "R12 gap after region 3");
        chk(last_gap == 4, "R12 idle clocks after region 3", last_gap, 4);
        run(32'h0000_000C, 0, 4, 0, 0, '{1},             1, 0, "R12 gap after region 0");
        chk(last_gap == 1, "R12 minimum idle clock", last_gap, 1);
        repeat (6) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule